// File: doc/BRIEF.md
# SPI Register Frame Engine

This block is an SPI master that performs one 16-bit register access on a sensor per request, with CRC protection on every frame. A request carries a 5-bit register address, a read/write flag and a 16-bit write value. The engine forms a 32-bit command frame, appends an inverted CRC-8 and shifts the frame out in SPI mode 0. The sensor answers a command in the frame that follows it, so the engine always runs a second frame to collect that answer.

When the second frame ends, the engine checks the answer's CRC and its return-status field. It then gives a one-cycle completion pulse that carries the sign-extended data and two error flags. The engine owns every pin-level timing detail: the SCLK divider, chip-select release between frames and the minimum idle time between frames. The client only sees a valid/ready request port and a completion pulse.

Top module: `spi_reg_engine`

## Requirements
- R1: The first frame of an access sends the command byte in bits [31:24] as {write flag, address[4:0], 2'b00}. The data field in bits [23:8] carries the write value for a write and is all zeros for a read, whatever value is on the write-data input.
- R2: Bits [7:0] of the first frame hold the bitwise inverse of a CRC-8 over bits [31:8]. The CRC uses polynomial 0x1D, starts at 0xFF and processes the bits most significant first.
- R3: Every access uses exactly two frames. Chip select goes high between them, and the second frame transmits 32 zero bits.
- R4: SPI mode 0 is used, with the most significant bit first. SCLK is low whenever chip select is high, and MOSI changes only while SCLK is low.
- R5: After a frame ends, chip select stays high for at least GAP_CYC clock cycles before the next frame starts. This holds both inside an access and between accesses.
- R6: The CRC error flag on completion is 1 exactly when bits [7:0] of the second received frame differ from the inverted CRC-8 (as in R2) of bits [31:8] of that frame.
- R7: The status error flag on completion is 1 exactly when bits [25:24] of the second received frame equal 2'b11.
- R8: The completion data is bits [23:8] of the second received frame, sign-extended to OUT_W bits.
- R9: req_ready is high only while the engine is idle, and it drops in the cycle after a request is accepted. done is a single-cycle pulse, one per access.
- R10: After reset, chip select is high, SCLK is low, req_ready is high and done is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Engine idle and able to take a request |
| req_addr | input | 5 | Register address |
| req_write | input | 1 | 1 = write access, 0 = read access |
| req_wdata | input | 16 | Value to write |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | OUT_W | Sign-extended reply data, valid with done |
| crc_err | output | 1 | Reply CRC mismatch, valid with done |
| status_err | output | 1 | Reply reported a device error, valid with done |
| spi_sclk | output | 1 | SPI clock |
| spi_cs_n | output | 1 | SPI chip select, active low |
| spi_mosi | output | 1 | Master-out data |
| spi_miso | input | 1 | Master-in data |

## Verification
Accesses are tried as reads with a non-zero value on the write-data input, which shows whether the data field is forced to zero. Writes at the lowest and highest addresses show whether the write bit and the address bits land in the right place in the command byte. Each reply is built with a chosen status and data: a positive value, a value with bit 15 set, a status of 3, and a deliberately corrupted CRC byte. Together these separate sign extension, status decoding and CRC checking from one another. Every captured frame and every inter-frame gap is compared with values that the bench computes, so slips in bit order or in frame count become visible.

// File: rtl/spi_frame_pkg.sv
package spi_frame_pkg;

  localparam int FRAME_BITS = 32;
  localparam int ADDR_W     = 5;
  localparam int FIELD_W    = 16;
  localparam int BYTE_W     = 8;

  localparam logic [7:0] CRC_POLY = 8'h1D;
  localparam logic [7:0] CRC_SEED = 8'hFF;
  localparam logic [1:0] RS_FAULT = 2'b11;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CMD,
    ST_GAP_MID,
    ST_RSP,
    ST_GAP_END
  } eng_state_t;

  // Byte-wise CRC-8 over a 24-bit payload, result inverted.
  function automatic logic [7:0] frame_crc(input logic [23:0] payload);
    logic [7:0] acc;
    acc = CRC_SEED;
    for (int b = 2; b >= 0; b--) begin
      acc = acc ^ payload[b*8 +: 8];
      for (int k = 0; k < 8; k++) begin
        if (acc[7]) acc = {acc[6:0], 1'b0} ^ CRC_POLY;
        else        acc = {acc[6:0], 1'b0};
      end
    end
    return ~acc;
  endfunction

  function automatic logic [7:0] cmd_byte(input logic wr, input logic [ADDR_W-1:0] addr);
    return {wr, addr, 2'b00};
  endfunction

  function automatic logic [FRAME_BITS-1:0] build_frame(input logic wr,
                                                        input logic [ADDR_W-1:0] addr,
                                                        input logic [FIELD_W-1:0] wdata);
    logic [23:0] body;
    body = {cmd_byte(wr, addr), (wr ? wdata : {FIELD_W{1'b0}})};
    return {body, frame_crc(body)};
  endfunction

endpackage

// File: rtl/spi_bit_engine.sv
module spi_bit_engine #(
  parameter int CLK_DIV    = 4,
  parameter int FRAME_BITS = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  logic [FRAME_BITS-1:0] tx_word,
  output logic                  busy,
  output logic                  fin,
  output logic [FRAME_BITS-1:0] rx_word,
  output logic                  sclk,
  output logic                  cs_n,
  output logic                  mosi,
  input  logic                  miso
);
  localparam int DIV_W = (CLK_DIV < 2) ? 1 : $clog2(CLK_DIV);
  localparam int BIT_W = $clog2(FRAME_BITS);
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(CLK_DIV - 1);
  localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(FRAME_BITS - 1);

  logic                  active;
  logic                  phase_hi;
  logic [DIV_W-1:0]      div_cnt;
  logic [BIT_W-1:0]      bit_cnt;
  logic [FRAME_BITS-1:0] tx_sh;
  logic [FRAME_BITS-1:0] rx_sh;
  logic                  sclk_q, cs_q, fin_q;

  // named events for the checks below
  logic half_end, rise_evt, fall_evt, last_bit;
  assign half_end = active && (div_cnt == DIV_LAST);
  assign rise_evt = half_end && !phase_hi;
  assign fall_evt = half_end && phase_hi;
  assign last_bit = (bit_cnt == BIT_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active   <= 1'b0;
      phase_hi <= 1'b0;
      div_cnt  <= '0;
      bit_cnt  <= '0;
      tx_sh    <= '0;
      rx_sh    <= '0;
      sclk_q   <= 1'b0;
      cs_q     <= 1'b1;
      fin_q    <= 1'b0;
    end else begin
      fin_q <= 1'b0;
      if (start && !active) begin
        active   <= 1'b1;
        cs_q     <= 1'b0;
        tx_sh    <= tx_word;
        div_cnt  <= '0;
        bit_cnt  <= '0;
        phase_hi <= 1'b0;
      end else if (active) begin
        div_cnt <= half_end ? '0 : div_cnt + 1'b1;
        if (rise_evt) begin
          sclk_q   <= 1'b1;
          phase_hi <= 1'b1;
          rx_sh    <= {rx_sh[FRAME_BITS-2:0], miso};
        end
        if (fall_evt) begin
          sclk_q   <= 1'b0;
          phase_hi <= 1'b0;
          if (last_bit) begin
            active <= 1'b0;
            cs_q   <= 1'b1;
            fin_q  <= 1'b1;
          end else begin
            bit_cnt <= bit_cnt + 1'b1;
            tx_sh   <= {tx_sh[FRAME_BITS-2:0], 1'b0};
          end
        end
      end
    end
  end

  assign busy    = active;
  assign fin     = fin_q;
  assign rx_word = rx_sh;
  assign sclk    = sclk_q;
  assign cs_n    = cs_q;
  assign mosi    = tx_sh[FRAME_BITS-1];

  AST_SCLK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sclk) else $error("sclk high while deselected"); // R4

  AST_MOSI_HOLD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk && $past(sclk)) |-> $stable(mosi)) else $error("mosi moved during sclk high"); // R4

  AST_FIN_DESELECTS: assert property (@(posedge clk) disable iff (!rst_n)
    fin |-> cs_n) else $error("frame end without deselect"); // R3

endmodule

// File: rtl/frame_gap_timer.sv
module frame_gap_timer #(
  parameter int GAP_CYC = 1250
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  output logic expired
);
  localparam int CNT_W = (GAP_CYC < 2) ? 1 : $clog2(GAP_CYC);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(GAP_CYC - 1);

  logic [CNT_W-1:0] cnt;
  logic             running;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      running <= 1'b0;
    end else if (load) begin
      cnt     <= '0;
      running <= 1'b1;
    end else if (running) begin
      if (cnt == CNT_LAST) running <= 1'b0;
      else                 cnt     <= cnt + 1'b1;
    end
  end

  assign expired = running && (cnt == CNT_LAST) && !load;

endmodule

// File: rtl/reply_decoder.sv
module reply_decoder
  import spi_frame_pkg::*;
#(
  parameter int OUT_W = 32
) (
  input  logic [FRAME_BITS-1:0] rx_word,
  output logic [OUT_W-1:0]      data_ext,
  output logic                  crc_bad,
  output logic                  status_fault
);
  logic signed [FIELD_W-1:0] field;
  assign field        = $signed(rx_word[23:8]);
  assign data_ext     = OUT_W'(field);
  assign crc_bad      = (frame_crc(rx_word[31:8]) != rx_word[7:0]);
  assign status_fault = (rx_word[25:24] == RS_FAULT);
endmodule

// File: rtl/spi_reg_engine.sv
module spi_reg_engine
  import spi_frame_pkg::*;
#(
  parameter int CLK_DIV = 4,
  parameter int GAP_CYC = 1250,
  parameter int OUT_W   = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [4:0]         req_addr,
  input  logic               req_write,
  input  logic [15:0]        req_wdata,
  output logic               done,
  output logic [OUT_W-1:0]   rd_data,
  output logic               crc_err,
  output logic               status_err,
  output logic               spi_sclk,
  output logic               spi_cs_n,
  output logic               spi_mosi,
  input  logic               spi_miso
);
  localparam int GAPC_W = $clog2(GAP_CYC + 2);
  localparam logic [GAPC_W-1:0] GAP_SAT = GAPC_W'(GAP_CYC);

  eng_state_t            state;
  logic                  accept, frame_start, frame_fin, gap_load, gap_exp;
  logic [FRAME_BITS-1:0] tx_word, rx_word;
  logic                  eng_busy;
  logic [OUT_W-1:0]      dec_data;
  logic                  dec_crc_bad, dec_fault;
  logic                  done_q, crc_q, fault_q;
  logic [OUT_W-1:0]      data_q;

  assign req_ready   = (state == ST_IDLE);
  assign accept      = req_valid && req_ready;
  assign frame_start = accept || (state == ST_GAP_MID && gap_exp);
  assign gap_load    = frame_fin;
  assign tx_word     = (state == ST_IDLE) ? build_frame(req_write, req_addr, req_wdata)
                                          : '0;

  spi_bit_engine #(.CLK_DIV(CLK_DIV), .FRAME_BITS(FRAME_BITS)) u_bits (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (frame_start),
    .tx_word (tx_word),
    .busy    (eng_busy),
    .fin     (frame_fin),
    .rx_word (rx_word),
    .sclk    (spi_sclk),
    .cs_n    (spi_cs_n),
    .mosi    (spi_mosi),
    .miso    (spi_miso)
  );

  frame_gap_timer #(.GAP_CYC(GAP_CYC)) u_gap (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (gap_load),
    .expired (gap_exp)
  );

  reply_decoder #(.OUT_W(OUT_W)) u_dec (
    .rx_word      (rx_word),
    .data_ext     (dec_data),
    .crc_bad      (dec_crc_bad),
    .status_fault (dec_fault)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      done_q  <= 1'b0;
      crc_q   <= 1'b0;
      fault_q <= 1'b0;
      data_q  <= '0;
    end else begin
      done_q <= 1'b0;
      unique case (state)
        ST_IDLE:    if (accept)    state <= ST_CMD;
        ST_CMD:     if (frame_fin) state <= ST_GAP_MID;
        ST_GAP_MID: if (gap_exp)   state <= ST_RSP;
        ST_RSP: if (frame_fin) begin
          state   <= ST_GAP_END;
          done_q  <= 1'b1;
          data_q  <= dec_data;
          crc_q   <= dec_crc_bad;
          fault_q <= dec_fault;
        end
        ST_GAP_END: if (gap_exp)   state <= ST_IDLE;
        default:                   state <= ST_IDLE;
      endcase
    end
  end

  assign done       = done_q;
  assign rd_data    = data_q;
  assign crc_err    = crc_q;
  assign status_err = fault_q;

  // cycles chip select has been high, saturating; reset counts as a long gap
  logic [GAPC_W-1:0] cs_hi_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   cs_hi_cnt <= GAP_SAT;
    else if (!spi_cs_n)           cs_hi_cnt <= '0;
    else if (cs_hi_cnt < GAP_SAT) cs_hi_cnt <= cs_hi_cnt + 1'b1;
  end

  AST_GAP_MIN: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(spi_cs_n) |-> (cs_hi_cnt >= GAP_SAT)) else $error("inter-frame gap too short"); // R5

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done) else $error("done longer than one cycle"); // R9

  AST_READY_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (spi_cs_n && !eng_busy)) else $error("ready while a frame runs"); // R9

  AST_ONE_INFLIGHT: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready) else $error("ready stayed high after accept"); // R9

endmodule

// File: tb/tb_spi_reg_engine.sv
module tb_spi_reg_engine;
  localparam int CLK_DIV = 3;
  localparam int GAP_CYC = 24;
  localparam int OUT_W   = 32;
  localparam int MAX_CYC = 200000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [4:0]  req_addr = '0;
  logic        req_write = 1'b0;
  logic [15:0] req_wdata = '0;
  logic        done;
  logic [OUT_W-1:0] rd_data;
  logic crc_err, status_err;
  logic spi_sclk, spi_cs_n, spi_mosi;
  logic spi_miso = 1'b0;

  always #4 clk = ~clk;

  spi_reg_engine #(.CLK_DIV(CLK_DIV), .GAP_CYC(GAP_CYC), .OUT_W(OUT_W)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_write(req_write), .req_wdata(req_wdata),
    .done(done), .rd_data(rd_data), .crc_err(crc_err), .status_err(status_err),
    .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi), .spi_miso(spi_miso)
  );

  int checks = 0;
  int failures = 0;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // bit-serial CRC restatement
  function automatic logic [7:0] ref_crc(input logic [23:0] d);
    logic [7:0] c;
    logic fb;
    c = 8'hFF;
    for (int i = 23; i >= 0; i--) begin
      fb = c[7] ^ d[i];
      c = {c[6:0], 1'b0};
      if (fb) c = c ^ 8'h1D;
    end
    return ~c;
  endfunction

  typedef struct { logic [31:0] word; int kind; } frame_exp_t;
  typedef struct { logic [31:0] data; logic crc; logic stat; } result_t;

  frame_exp_t  frame_q[$];
  result_t     result_q[$];
  logic [31:0] reply_q[$];

  // ---- sensor model ----
  logic [31:0] slv_tx = '0, slv_rx = '0;
  int          slv_bits = 0;
  realtime     t_rise = 0;
  bit          seen_frame = 0;

  always @(negedge spi_cs_n) begin
    if (seen_frame) check(($time - t_rise) / 8 >= GAP_CYC, "R5 gap", 32'(int'(($time - t_rise) / 8)), GAP_CYC);
    check(spi_sclk == 1'b0, "R4 sclk low at select", {31'b0, spi_sclk}, 0);
    slv_tx   = (reply_q.size() > 0) ? reply_q.pop_front() : 32'h0;
    spi_miso = slv_tx[31];
    slv_rx   = '0;
    slv_bits = 0;
  end

  always @(posedge spi_sclk) if (!spi_cs_n) begin
    slv_rx = {slv_rx[30:0], spi_mosi};
    slv_bits++;
  end

  always @(negedge spi_sclk) if (!spi_cs_n) begin
    slv_tx   = {slv_tx[30:0], 1'b0};
    spi_miso = slv_tx[31];
  end

  always @(posedge spi_cs_n) if (slv_bits == 32) begin
    frame_exp_t e;
    t_rise = $time;
    seen_frame = 1;
    slv_bits = 0;
    if (frame_q.size() == 0) check(0, "R3 unexpected frame", slv_rx, 0);
    else begin
      e = frame_q.pop_front();
      if (e.kind == 1) begin
        check(slv_rx[31:8] == e.word[31:8], "R1 command and data", slv_rx, e.word);
        check(slv_rx[7:0] == e.word[7:0], "R2 crc byte", {24'b0, slv_rx[7:0]}, {24'b0, e.word[7:0]});
      end else begin
        check(slv_rx == 32'h0, "R3 second frame zeros", slv_rx, 0);
      end
    end
  end

  // ---- result monitor ----
  logic prev_done = 1'b0;
  always @(negedge clk) begin
    if (done) begin
      result_t r;
      if (result_q.size() == 0) check(0, "R9 unexpected done", rd_data, 0);
      else begin
        r = result_q.pop_front();
        check(rd_data == r.data, "R8 data sign extension", rd_data, r.data);
        check(crc_err == r.crc, "R6 crc flag", {31'b0, crc_err}, {31'b0, r.crc});
        check(status_err == r.stat, "R7 status flag", {31'b0, status_err}, {31'b0, r.stat});
      end
    end
    if (done && prev_done) check(0, "R9 done pulse width", 2, 1);
    prev_done = done;
  end

  function automatic logic [31:0] make_reply(input logic [1:0] rs, input logic [15:0] d, input bit corrupt);
    logic [23:0] body;
    logic [7:0]  c;
    body = {6'b000000, rs, d};
    c = ref_crc(body);
    if (corrupt) c = c ^ 8'h40;
    return {body, c};
  endfunction

  // ---- driver ----
  task automatic do_access(input logic [4:0] addr, input logic wr, input logic [15:0] wdata,
                           input logic [1:0] rs, input logic [15:0] rdat, input bit corrupt);
    logic [23:0] body;
    frame_exp_t  f;
    result_t     r;
    body = {wr, addr, 2'b00, (wr ? wdata : 16'h0000)};
    f.word = {body, ref_crc(body)}; f.kind = 1; frame_q.push_back(f);
    f.word = 32'h0;                 f.kind = 2; frame_q.push_back(f);
    reply_q.push_back(32'hA5C3_3C5A);
    reply_q.push_back(make_reply(rs, rdat, corrupt));
    r.data = {{16{rdat[15]}}, rdat};
    r.crc  = corrupt;
    r.stat = (rs == 2'b11);
    result_q.push_back(r);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_addr = addr; req_write = wr; req_wdata = wdata;
    @(negedge clk);
    req_valid = 1'b0;
    check(req_ready == 1'b0, "R9 ready drops after accept", {31'b0, req_ready}, 0);
  endtask

  initial begin
    int cyc = 0;
    while (cyc < MAX_CYC) begin
      @(posedge clk);
      cyc++;
    end
    check(0, "watchdog", cyc, MAX_CYC);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(spi_cs_n == 1'b1, "R10 cs high", {31'b0, spi_cs_n}, 1);
    check(spi_sclk == 1'b0, "R10 sclk low", {31'b0, spi_sclk}, 0);
    check(req_ready == 1'b1, "R10 ready high", {31'b0, req_ready}, 1);
    check(done == 1'b0, "R10 done low", {31'b0, done}, 0);

    do_access(5'h10, 1'b0, 16'hBEEF, 2'b01, 16'h1234, 0); // read, data input ignored
    do_access(5'h1F, 1'b1, 16'h8001, 2'b01, 16'h0000, 0); // write, top address
    do_access(5'h00, 1'b1, 16'h7FFE, 2'b00, 16'h8001, 0); // write, address zero, negative reply
    do_access(5'h06, 1'b0, 16'h0000, 2'b11, 16'h01FF, 0); // device error status
    do_access(5'h01, 1'b0, 16'hFFFF, 2'b01, 16'hFFFF, 1); // corrupted reply crc
    do_access(5'h05, 1'b0, 16'h0000, 2'b10, 16'h7FFF, 0); // status 2 is not an error
    do_access(5'h0D, 1'b1, 16'h0020, 2'b11, 16'hC000, 1); // both flags

    while (result_q.size() != 0 || !req_ready) @(negedge clk);
    repeat (4) @(negedge clk);
    check(frame_q.size() == 0, "R3 two frames per access", frame_q.size(), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule